// File: doc/BRIEF.md
# Serial TDM Time-Slot Interchange Switch

This block reorders the channels of a set of serial time-division-multiplexed streams. One shared bit clock carries one bit per cycle on every input and output stream, and a one-cycle frame pulse marks the last bit of each frame. Every frame holds `NCHAN` byte-wide channels per stream, sent most significant bit first. Each incoming byte goes into a frame-wide data memory. Each output slot (stream, channel) then reads its own entry in a connection table. That entry either names the source stream and channel whose byte from the previous frame is replayed in the slot, or it carries a fixed message byte that is sent as it stands.

A host register port gives read and write access to the connection table and read-only access to the data memory, so the host can watch live channel contents. Table writes go into a shadow copy that is moved to the working copy at each frame boundary. The frame-pulse polarity is not configured. After reset a controller samples the pulse line for one frame and locks on to active-low pulses (idle level high) or active-high pulses (idle level low). It then waits for a pulse (ALIGN), spends one frame filling the data memory (FILL), and only then starts switching (RUN). The four controller states are DETECT, ALIGN, FILL and RUN. The transitions are DETECT→ALIGN once one frame length of samples has been taken, ALIGN→FILL on the first pulse of the locked polarity, and FILL→RUN on the next pulse. RUN holds until reset.

Top module: `tsi_switch`

## Requirements
- R1: During reset, and after it until switching starts, every output stream is held at logic 1. `host_rdata` resets to 0 and the whole connection table resets to 0.
- R2: A frame is `NCHAN*8` bit cycles long, and the pulse cycle is bit `NCHAN*8-1` of the frame. Bit `8*c+k` carries bit `7-k` of channel `c`. The output byte in a slot of frame N+1 is built from input bytes of frame N.
- R3: A connection entry with bit 8 = 0 sends, in output slot (o, c), the previous frame's byte from input stream `entry[6:5]`, channel `entry[4:0]`.
- R4: A connection entry with bit 8 = 1 sends `entry[7:0]` in its own slot in every frame, whatever the input data. The choice is made per slot.
- R5: With `host_addr[7]` = 0, `host_addr[6:0]` = {stream[1:0], channel[4:0]} selects a connection entry. A `host_wr` cycle writes `host_wdata` to it. A `host_rd` cycle returns the stored entry on `host_rdata` after the next clock edge.
- R6: With `host_addr[7]` = 1, a read returns the byte of input stream `host_addr[6:5]`, channel `host_addr[4:0]` from the last completed frame, zero-extended. A write to that range changes neither the data memory nor the connection table.
- R7: A connection write made during a frame does not change that frame's output in any slot. It applies from the following frame onward.
- R8: The pulse polarity is chosen from the majority level seen over the first frame length after reset. A mostly-high line means active-low pulses, and a mostly-low line means active-high pulses. The choice is held until the next reset.
- R9: Switched data appears only from the third full frame that starts after reset is released. The two frames before it are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one bit per cycle on every stream |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_i | input | 1 | Frame pulse, one cycle wide, polarity auto-detected |
| din_i | input | NSTRM (4) | Serial input streams |
| dout_o | output | NSTRM (4) | Serial output streams |
| host_addr | input | IDX_W+1 (8) | Host address: top bit picks data memory, rest is {stream, channel} |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | ENTRY_W (9) | Host write data (connection entry) |
| host_rdata | output | ENTRY_W (9) | Registered host read data |

## Verification
The assertions assume that after reset the frame pulse keeps one polarity, lasts exactly one cycle and repeats exactly every `NCHAN*8` cycles. A pulse at any other spacing would break the position and boundary relations they check. The bench meets this by deriving the pulse and every data bit from one free-running bit counter, and it changes polarity only while reset is held. Host accesses are one-cycle strobes driven away from the clock edge. Reset is released on a frame-pulse cycle, so the two hold frames and the first switched frame fall on frame indices the bench already knows.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Bits carried by one channel slot on a serial stream.
    localparam int SLOT_BITS = 8;

    // Frame synchronisation phases.
    typedef enum logic [1:0] {
        ST_DETECT = 2'd0,   // sampling the pulse line to learn its polarity
        ST_ALIGN  = 2'd1,   // polarity known, waiting for the first pulse
        ST_FILL   = 2'd2,   // capturing one full frame, outputs idle
        ST_RUN    = 2'd3    // switching active
    } sync_state_t;

endpackage

// File: rtl/tsi_frame_ctrl.sv
module tsi_frame_ctrl
    import tsi_pkg::*;
#(
    parameter  int FRAME_LEN = 256,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    output logic [POS_W-1:0] pos_o,
    output logic             frame_tick_o,
    output logic             wr_en_o,
    output logic             run_o,
    output logic             bank_o
);

    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);
    localparam int               HALF = FRAME_LEN / 2;

    sync_state_t      state_q, state_d;
    logic [POS_W-1:0] pos_q;
    logic [POS_W:0]   hi_q;
    logic [POS_W:0]   hi_total;
    logic             style_low_q;
    logic             bank_q;
    logic             pulse;
    logic             at_last;

    assign at_last  = (pos_q == LAST);
    assign pulse    = style_low_q ? ~fp_i : fp_i;
    assign hi_total = hi_q + {{POS_W{1'b0}}, fp_i};

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_DETECT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DETECT: if (at_last) state_d = ST_ALIGN;
            ST_ALIGN:  if (pulse)   state_d = ST_FILL;
            ST_FILL:   if (pulse)   state_d = ST_RUN;
            ST_RUN:                 state_d = ST_RUN;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        frame_tick_o = pulse && (state_q != ST_DETECT);
        wr_en_o      = (state_q == ST_FILL) || (state_q == ST_RUN);
        run_o        = (state_q == ST_RUN);
    end

    // Bit position, polarity vote and bank select.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q       <= '0;
            hi_q        <= '0;
            style_low_q <= 1'b1;
            bank_q      <= 1'b0;
        end else begin
            if (state_q == ST_DETECT) begin
                hi_q <= hi_total;
                if (at_last) begin
                    style_low_q <= (hi_total > (POS_W+1)'(HALF));
                end
            end
            if (frame_tick_o) begin
                pos_q  <= '0;
                bank_q <= ~bank_q;
            end else begin
                pos_q <= at_last ? '0 : pos_q + POS_W'(1);
            end
        end
    end

    assign pos_o  = pos_q;
    assign bank_o = bank_q;

    // R8: polarity never changes once the detect phase is over.
    a_r8_style_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DETECT && $past(state_q) != ST_DETECT) |-> $stable(style_low_q));

    // R9: switching is entered only from the fill frame.
    a_r9_run_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> ($past(state_q) == ST_FILL || $past(state_q) == ST_RUN));

    // R9: switching starts exactly at a frame pulse.
    a_r9_run_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> $past(pulse));

    // R2: every accepted pulse restarts the bit position at zero.
    a_r2_tick_realigns: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick_o |=> (pos_q == '0));

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
    import tsi_pkg::*;
#(
    parameter  int NSTRM = 4,
    parameter  int NCHAN = 32,
    localparam int SW    = $clog2(NSTRM),
    localparam int CW    = $clog2(NCHAN),
    localparam int IDX_W = SW + CW,
    localparam int DEPTH = NSTRM * NCHAN,
    localparam int POS_W = CW + $clog2(SLOT_BITS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSTRM-1:0]            din,
    input  logic [POS_W-1:0]            pos,
    input  logic                        wr_en,
    input  logic                        bank,
    input  logic [NSTRM-1:0][IDX_W-1:0] tx_idx,
    input  logic [IDX_W-1:0]            host_idx,
    output logic [NSTRM-1:0][7:0]       tx_byte,
    output logic [7:0]                  host_byte
);

    logic [NSTRM-1:0][6:0] shift_q;
    logic [7:0]            mem_q [2][DEPTH];
    logic                  byte_done;
    logic                  rd_bank;
    logic [CW-1:0]         chan;

    assign byte_done = wr_en && (pos[2:0] == 3'd7);
    assign rd_bank   = ~bank;
    assign chan      = pos[POS_W-1:3];

    // Deserialisers, most significant bit first.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            for (int s = 0; s < NSTRM; s++) begin
                shift_q[s] <= {shift_q[s][5:0], din[s]};
            end
        end
    end

    // Write the finished byte of every stream into the current frame bank.
    always_ff @(posedge clk) begin
        if (byte_done) begin
            for (int s = 0; s < NSTRM; s++) begin
                mem_q[bank][{SW'(s), chan}] <= {shift_q[s], din[s]};
            end
        end
    end

    // Reads always come from the bank holding the last completed frame.
    always_comb begin
        for (int o = 0; o < NSTRM; o++) begin
            tx_byte[o] = mem_q[rd_bank][tx_idx[o]];
        end
        host_byte = mem_q[rd_bank][host_idx];
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter  int NSTRM   = 4,
    parameter  int NCHAN   = 32,
    parameter  int ENTRY_W = 9,
    localparam int SW      = $clog2(NSTRM),
    localparam int CW      = $clog2(NCHAN),
    localparam int IDX_W   = SW + CW,
    localparam int DEPTH   = NSTRM * NCHAN
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          host_we,
    input  logic [IDX_W-1:0]              host_idx,
    input  logic [ENTRY_W-1:0]            host_wdata,
    input  logic                          frame_tick,
    input  logic [CW-1:0]                 chan,
    output logic [ENTRY_W-1:0]            host_entry,
    output logic [NSTRM-1:0][ENTRY_W-1:0] cur_entry
);

    logic [DEPTH-1:0][ENTRY_W-1:0] shadow_q;
    logic [DEPTH-1:0][ENTRY_W-1:0] active_q;

    // Host writes land in the shadow table; the working table follows
    // only at a frame boundary.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            active_q <= '0;
        end else begin
            if (host_we) begin
                shadow_q[host_idx] <= host_wdata;
            end
            if (frame_tick) begin
                active_q <= shadow_q;
            end
        end
    end

    assign host_entry = shadow_q[host_idx];

    generate
        for (genvar o = 0; o < NSTRM; o++) begin : g_lookup
            assign cur_entry[o] = active_q[{SW'(o), chan}];
        end
    endgenerate

    // R7: the working table holds still for the whole frame.
    a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(active_q));

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
    parameter int NSTRM   = 4,
    parameter int IDX_W   = 7,
    parameter int ENTRY_W = 9
) (
    input  logic [NSTRM-1:0][ENTRY_W-1:0] cur_entry,
    input  logic [NSTRM-1:0][7:0]         dm_byte,
    input  logic [2:0]                    bit_idx,
    input  logic                          run,
    output logic [NSTRM-1:0][IDX_W-1:0]   src_idx,
    output logic [NSTRM-1:0]              dout
);

    generate
        for (genvar o = 0; o < NSTRM; o++) begin : g_out
            logic       is_msg;
            logic [7:0] slot_byte;

            assign is_msg     = cur_entry[o][ENTRY_W-1];
            assign src_idx[o] = cur_entry[o][IDX_W-1:0];
            assign slot_byte  = is_msg ? cur_entry[o][7:0] : dm_byte[o];
            assign dout[o]    = run ? slot_byte[3'd7 - bit_idx] : 1'b1;
        end
    endgenerate

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter  int NSTRM     = 4,
    parameter  int NCHAN     = 32,
    localparam int SW        = $clog2(NSTRM),
    localparam int CW        = $clog2(NCHAN),
    localparam int IDX_W     = SW + CW,
    localparam int PAY_W     = (IDX_W > 8) ? IDX_W : 8,
    localparam int ENTRY_W   = PAY_W + 1,
    localparam int AW        = IDX_W + 1,
    localparam int FRAME_LEN = NCHAN * SLOT_BITS,
    localparam int POS_W     = $clog2(FRAME_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fp_i,
    input  logic [NSTRM-1:0]   din_i,
    output logic [NSTRM-1:0]   dout_o,
    input  logic [AW-1:0]      host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [ENTRY_W-1:0] host_wdata,
    output logic [ENTRY_W-1:0] host_rdata
);

    logic [POS_W-1:0]              pos;
    logic                          frame_tick;
    logic                          wr_en;
    logic                          run;
    logic                          bank;
    logic [NSTRM-1:0][IDX_W-1:0]   src_idx;
    logic [NSTRM-1:0][7:0]         dm_byte;
    logic [NSTRM-1:0][ENTRY_W-1:0] cur_entry;
    logic [7:0]                    dm_host_byte;
    logic [ENTRY_W-1:0]            cm_host_entry;
    logic                          sel_dm;
    logic [IDX_W-1:0]              host_idx;

    assign sel_dm   = host_addr[AW-1];
    assign host_idx = host_addr[IDX_W-1:0];

    tsi_frame_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fp_i         (fp_i),
        .pos_o        (pos),
        .frame_tick_o (frame_tick),
        .wr_en_o      (wr_en),
        .run_o        (run),
        .bank_o       (bank)
    );

    tsi_rx #(.NSTRM(NSTRM), .NCHAN(NCHAN)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din_i),
        .pos       (pos),
        .wr_en     (wr_en),
        .bank      (bank),
        .tx_idx    (src_idx),
        .host_idx  (host_idx),
        .tx_byte   (dm_byte),
        .host_byte (dm_host_byte)
    );

    tsi_conn_mem #(.NSTRM(NSTRM), .NCHAN(NCHAN), .ENTRY_W(ENTRY_W)) u_cm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_wr && !sel_dm),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .frame_tick (frame_tick),
        .chan       (pos[POS_W-1:3]),
        .host_entry (cm_host_entry),
        .cur_entry  (cur_entry)
    );

    tsi_tx #(.NSTRM(NSTRM), .IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_tx (
        .cur_entry (cur_entry),
        .dm_byte   (dm_byte),
        .bit_idx   (pos[2:0]),
        .run       (run),
        .src_idx   (src_idx),
        .dout      (dout_o)
    );

    // Registered host read path.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= sel_dm ? ENTRY_W'(dm_host_byte) : cm_host_entry;
        end
    end

    // R5: read data changes only in answer to a read strobe.
    a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    // R1: outputs stay idle while switching is not running.
    a_r1_idle_until_run: assert property (@(posedge clk) disable iff (!rst_n)
        !u_ctrl.run_o |-> (dout_o == '1));

endmodule

// File: tb/tsi_switch_tb.sv
`timescale 1ns/1ps
module tsi_switch_tb;

    localparam int NS = 4;
    localparam int NC = 32;
    localparam int FL = NC * 8;
    localparam int EW = 9;
    localparam int AW = 8;

    logic          clk    = 1'b0;
    logic          rst_n  = 1'b0;
    logic          fp     = 1'b1;
    logic          gci    = 1'b0;
    logic [NS-1:0] din    = '0;
    logic [NS-1:0] dout;
    logic [AW-1:0] haddr  = '0;
    logic          hwr    = 1'b0;
    logic          hrd    = 1'b0;
    logic [EW-1:0] hwdata = '0;
    logic [EW-1:0] hrdata;

    int n_tests = 0;
    int n_fail  = 0;
    int bpos      = 0;
    int frame_cnt = 0;
    int done_idx  = -1;

    logic [7:0]    cap [NS][NC];
    logic [7:0]    got [NS][NC];
    logic [EW-1:0] cm_model [NS*NC];
    event          frame_done;

    always #2.5 clk = ~clk;

    tsi_switch #(.NSTRM(NS), .NCHAN(NC)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_i       (fp),
        .din_i      (din),
        .dout_o     (dout),
        .host_addr  (haddr),
        .host_wr    (hwr),
        .host_rd    (hrd),
        .host_wdata (hwdata),
        .host_rdata (hrdata)
    );

    function automatic logic [7:0] pat(int fr, int s, int c);
        return 8'(fr * 29 + s * 71 + c * 13 + 5);
    endfunction

    // Frame generator and output capture, one bit per negedge.
    always @(negedge clk) begin
        logic [7:0] b;
        for (int s = 0; s < NS; s++) begin
            b = pat(frame_cnt, s, bpos / 8);
            din[s] = b[7 - bpos % 8];
        end
        fp = (bpos == FL - 1) ? gci : ~gci;
        for (int o = 0; o < NS; o++) begin
            cap[o][bpos / 8][7 - bpos % 8] = dout[o];
        end
        if (bpos == FL - 1) begin
            got = cap;
            done_idx = frame_cnt;
            frame_cnt++;
            bpos = 0;
            -> frame_done;
        end else begin
            bpos++;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_frame(string req, bit idle);
        int bad = 0;
        logic [7:0] e;
        logic [EW-1:0] ent;
        for (int o = 0; o < NS; o++) begin
            for (int c = 0; c < NC; c++) begin
                ent = cm_model[o * NC + c];
                if (idle) e = 8'hFF;
                else if (ent[8]) e = ent[7:0];
                else e = pat(done_idx - 1, int'(ent[6:5]), int'(ent[4:0]));
                if (got[o][c] !== e) begin
                    if (bad == 0)
                        $display("FAIL %s frame %0d out %0d ch %0d: got %h expected %h",
                                 req, done_idx, o, c, got[o][c], e);
                    bad++;
                end
            end
        end
        n_tests++;
        if (bad != 0) n_fail++;
    endtask

    task automatic host_write(logic [AW-1:0] a, logic [EW-1:0] d);
        @(negedge clk);
        haddr = a; hwdata = d; hwr = 1'b1;
        @(negedge clk);
        hwr = 1'b0;
    endtask

    task automatic host_read(logic [AW-1:0] a, output logic [EW-1:0] d);
        @(negedge clk);
        haddr = a; hrd = 1'b1;
        @(negedge clk);
        hrd = 1'b0;
        d = hrdata;
    endtask

    function automatic logic [AW-1:0] cm_addr(int s, int c);
        return AW'(s * NC + c);
    endfunction

    function automatic logic [AW-1:0] dm_addr(int s, int c);
        return AW'(128 + s * NC + c);
    endfunction

    // Reset, then release on a pulse cycle; check idle state and hold frames.
    task automatic test_reset_hold(bit style_gci, string tag);
        gci = style_gci;
        rst_n = 1'b0;
        for (int i = 0; i < NS * NC; i++) cm_model[i] = '0;
        #1;
        chk("R1", {tag, " dout during reset"}, 32'(dout), 32'hF);
        chk("R1", {tag, " host_rdata reset"}, 32'(hrdata), 32'h0);
        repeat (2) @(frame_done);
        rst_n = 1'b1;
        @(frame_done);
        check_frame({"R9 first hold frame ", tag}, 1'b1);
        @(frame_done);
        check_frame({"R9 second hold frame ", tag}, 1'b1);
        @(frame_done);
        check_frame({"R8 R9 R3 default mapping switched ", tag}, 1'b0);
    endtask

    task automatic test_program_map();
        logic [EW-1:0] rd;
        logic [EW-1:0] ent;
        host_read(cm_addr(2, 9), rd);
        chk("R1 R5", "table entry after reset", 32'(rd), 32'h0);
        for (int o = 0; o < NS; o++) begin
            for (int c = 0; c < NC; c++) begin
                if (c % 4 == 3) begin
                    if (o == 0 && c == 3)       ent = {1'b1, 8'h00};
                    else if (o == 3 && c == 31) ent = {1'b1, 8'hFF};
                    else                        ent = {1'b1, 8'(c * 17 + o * 3)};
                end else begin
                    ent = EW'(((o + 1) % NS) * 32 + (NC - 1 - c));
                end
                cm_model[o * NC + c] = ent;
                host_write(cm_addr(o, c), ent);
            end
        end
        host_read(cm_addr(0, 3), rd);
        chk("R5", "message entry readback", 32'(rd), 32'h100);
        host_read(cm_addr(1, 26), rd);
        chk("R5", "connection entry readback", 32'(rd), 32'(cm_model[NC + 26]));
        @(frame_done);
        @(frame_done);
        check_frame("R2 R3 R4 permuted map with messages", 1'b0);
        @(frame_done);
        check_frame("R2 R3 R4 next frame new data", 1'b0);
    endtask

    task automatic test_dm_access();
        logic [EW-1:0] rd;
        int d;
        @(frame_done);
        d = done_idx;
        host_read(dm_addr(2, 5), rd);
        chk("R6", "data memory read s2 c5", 32'(rd), 32'(pat(d, 2, 5)));
        host_read(dm_addr(3, 31), rd);
        chk("R6", "data memory read s3 c31", 32'(rd), 32'(pat(d, 3, 31)));
        host_write(dm_addr(2, 5), 9'h03C);
        host_read(dm_addr(2, 5), rd);
        chk("R6", "data memory after host write", 32'(rd), 32'(pat(d, 2, 5)));
        host_read(cm_addr(2, 5), rd);
        chk("R6", "table entry after data write", 32'(rd), 32'(cm_model[2 * NC + 5]));
        @(frame_done);
        check_frame("R6 outputs after ignored data write", 1'b0);
    endtask

    task automatic test_boundary_update();
        @(frame_done);
        host_write(cm_addr(1, NC - 1), 9'h1A5);
        @(frame_done);
        check_frame("R7 frame of the write keeps old map", 1'b0);
        cm_model[NC + NC - 1] = 9'h1A5;
        @(frame_done);
        check_frame("R7 following frame uses new entry", 1'b0);
    endtask

    initial begin
        #600000;
        n_fail++;
        $display("FAIL watchdog all R: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset_hold(1'b0, "active-low pulse");
        test_program_map();
        test_dm_access();
        test_boundary_update();
        test_reset_hold(1'b1, "active-high pulse");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule